// File: doc/BRIEF.md
# Three-Branch Polyphase Decimating FIR Filter

This block reduces the sample rate of an 8-bit unsigned sample stream by three while applying an 18-tap low-pass FIR response. Rather than computing the full filter at the input rate and dropping two of every three results, it splits the 18 coefficients into three phase subfilters of six taps each. A commutator hands each accepted sample to one of the three subfilters in rotation. Each subfilter keeps its own six-deep delay line and computes its own six products only from the samples it was handed.

The first sample of every group of three goes to branch 2, the second to branch 1 and the third to branch 0. Once branch 0 has its sample, the three six-term partial sums are registered. A single three-input adder then combines them into one 32-bit decimated result, which is held in an output register and marked with a one-cycle strobe. Samples may arrive on consecutive clocks or with gaps of any length. The coefficients are fixed constants computed at elaboration time.

Top module: `pd_decim3`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `dout` to 0, `out_valid` to 0, every delay line and every partial sum, and makes the next accepted sample the first of a new group.
- R2: A sample is accepted on a rising edge where `in_valid` is 1. Accepted samples go to branch 2, branch 1 and branch 0 in that repeating order. While `in_valid` is 0, `in_sample` is ignored and neither the rotation nor any delay line moves.
- R3: Coefficient k (k = 0..17) equals 1 + ((23·k + 5) mod 62). Branch p (p = 0, 1, 2) multiplies its delay-line tap j (j = 0 newest .. 5 oldest) by coefficient 3·j + p.
- R4: Every product is an unsigned 14-bit value that never overflows, including full-scale input 255. Each partial sum and the output are 32-bit unsigned values.
- R5: Number the accepted samples since reset x[0], x[1], ... For group m (samples 3m, 3m+1, 3m+2), the output is y[m] = Σ_{k=0..17} h[k]·x[3m+2−k], where samples with a negative index count as 0.
- R6: `out_valid` is high for exactly one clock. It rises after the second rising edge following the edge that accepted the third sample of a group. `dout` changes only at that update.
- R7: Exactly one output is produced per three accepted samples, whatever the spacing of the samples; no strobe appears while fewer than three new samples have arrived.
- R8: Samples may be accepted on every clock without loss; back-to-back groups each produce their own output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_sample` carries a sample to accept |
| in_sample | input | 8 | Unsigned input sample |
| dout | output | 32 | Registered decimated filter output |
| out_valid | output | 1 | One-clock strobe marking a new `dout` value |

## Verification
A decimated result becomes visible two rising edges after the edge that accepts the third sample of its group: one edge registers the partial sums, and the next loads the output register. When the bench drives a group-completing sample, it records the cycle count seen at the following falling edge and marks the result due two cycles later. On every falling edge it compares `out_valid` and `dout` against that schedule. An early, late, missing or extra strobe is therefore reported, as well as a wrong value. Expected values come from a direct 18-tap convolution over the full sample history, with the coefficient rule evaluated separately in the bench.

// File: rtl/pd_pkg.sv
package pd_pkg;

  localparam int DATA_W_D = 8;
  localparam int COEF_W_D = 8;
  localparam int PROD_W_D = 14;
  localparam int ACC_W_D  = 32;
  localparam int NPHASE_D = 3;
  localparam int NTAPS_D  = 18;

  // Coefficient k of the prototype filter; values stay in 1..62 so that an
  // 8-bit sample times a coefficient fits in 14 bits.
  function automatic int coef_of(input int k);
    return ((23 * k + 5) % 62) + 1;
  endfunction

endpackage

// File: rtl/pd_commutator.sv
module pd_commutator #(
  parameter int NPHASE = pd_pkg::NPHASE_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic [NPHASE-1:0] br_en,
  output logic              grp_done
);
  localparam int PH_W = (NPHASE > 1) ? $clog2(NPHASE) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NPHASE - 1);

  logic [PH_W-1:0] phase;
  logic            take;

  assign take = in_valid && !rst;

  // Rotation runs from the highest branch down to branch 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= LAST_PH;
    end else if (in_valid) begin
      if (phase == '0) phase <= LAST_PH;
      else             phase <= phase - 1'b1;
    end
  end

  for (genvar p = 0; p < NPHASE; p++) begin : g_en
    assign br_en[p] = take && (phase == PH_W'(p));
  end

  assign grp_done = br_en[0];

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PH);
  // R2
  phase_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase));
  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase == '0) |=> phase == LAST_PH);
  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase != '0) |=> phase == $past(phase) - 1'b1);
  // R2
  en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(br_en));

endmodule

// File: rtl/pd_branch.sv
module pd_branch #(
  parameter int PHASE    = 0,
  parameter int NPHASE   = pd_pkg::NPHASE_D,
  parameter int TAPS_PER = pd_pkg::NTAPS_D / pd_pkg::NPHASE_D,
  parameter int DATA_W   = pd_pkg::DATA_W_D,
  parameter int COEF_W   = pd_pkg::COEF_W_D,
  parameter int PROD_W   = pd_pkg::PROD_W_D,
  parameter int ACC_W    = pd_pkg::ACC_W_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] din,
  input  logic              capture,
  output logic [ACC_W-1:0]  partial
);
  localparam int FULL_W = DATA_W + COEF_W;

  logic [TAPS_PER-1:0][DATA_W-1:0] line;
  logic [TAPS_PER-1:0][PROD_W-1:0] prod;
  logic [TAPS_PER-1:0]             prod_ovf;
  logic [ACC_W-1:0]                tap_sum;

  function automatic logic [FULL_W-1:0] full_mul(input logic [DATA_W-1:0] x,
                                                input logic [COEF_W-1:0] c);
    return FULL_W'(x) * FULL_W'(c);
  endfunction

  function automatic logic [ACC_W-1:0] add_taps(
      input logic [TAPS_PER-1:0][PROD_W-1:0] terms);
    logic [ACC_W-1:0] s;
    s = '0;
    for (int j = 0; j < TAPS_PER; j++) s = s + ACC_W'(terms[j]);
    return s;
  endfunction

  // Delay line: tap 0 holds the newest sample handed to this branch.
  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
    end else if (shift_en) begin
      line[0] <= din;
      for (int j = 1; j < TAPS_PER; j++) line[j] <= line[j-1];
    end
  end

  for (genvar j = 0; j < TAPS_PER; j++) begin : g_tap
    localparam logic [COEF_W-1:0] CVAL = COEF_W'(pd_pkg::coef_of(j * NPHASE + PHASE));
    logic [FULL_W-1:0] full;
    assign full        = full_mul(line[j], CVAL);
    assign prod[j]     = full[PROD_W-1:0];
    assign prod_ovf[j] = |full[FULL_W-1:PROD_W];
  end

  assign tap_sum = add_taps(prod);

  always_ff @(posedge clk) begin
    if (rst)          partial <= '0;
    else if (capture) partial <= tap_sum;
  end

  // R4
  prod_fit_chk: assert property (@(posedge clk) disable iff (rst)
    prod_ovf == '0);
  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(line));
  // R2
  line_load_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> line[0] == $past(din));
  // R1
  partial_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(partial));

endmodule

// File: rtl/pd_combine.sv
module pd_combine #(
  parameter int NPHASE = pd_pkg::NPHASE_D,
  parameter int ACC_W  = pd_pkg::ACC_W_D
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         go,
  input  logic [NPHASE-1:0][ACC_W-1:0] parts,
  output logic [ACC_W-1:0]             dout,
  output logic                         out_valid
);

  function automatic logic [ACC_W-1:0] sum_parts(
      input logic [NPHASE-1:0][ACC_W-1:0] v);
    logic [ACC_W-1:0] s;
    s = '0;
    for (int p = 0; p < NPHASE; p++) s = s + v[p];
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      dout      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= go;
      if (go) dout <= sum_parts(parts);
    end
  end

  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(dout));

endmodule

// File: rtl/pd_decim3.sv
module pd_decim3 #(
  parameter int DATA_W = pd_pkg::DATA_W_D,
  parameter int COEF_W = pd_pkg::COEF_W_D,
  parameter int PROD_W = pd_pkg::PROD_W_D,
  parameter int ACC_W  = pd_pkg::ACC_W_D,
  parameter int NPHASE = pd_pkg::NPHASE_D,
  parameter int NTAPS  = pd_pkg::NTAPS_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic [ACC_W-1:0]  dout,
  output logic              out_valid
);
  localparam int TAPS_PER = NTAPS / NPHASE;

  logic [NPHASE-1:0]             br_en;
  logic                          grp_done;
  logic                          cap_r;
  logic                          part_rdy;
  logic [NPHASE-1:0][ACC_W-1:0]  parts;

  pd_commutator #(.NPHASE(NPHASE)) u_comm (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .br_en    (br_en),
    .grp_done (grp_done)
  );

  // Stage 1 registers the partial sums, stage 2 the combined output.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_r    <= 1'b0;
      part_rdy <= 1'b0;
    end else begin
      cap_r    <= grp_done;
      part_rdy <= cap_r;
    end
  end

  for (genvar p = 0; p < NPHASE; p++) begin : g_br
    pd_branch #(
      .PHASE    (p),
      .NPHASE   (NPHASE),
      .TAPS_PER (TAPS_PER),
      .DATA_W   (DATA_W),
      .COEF_W   (COEF_W),
      .PROD_W   (PROD_W),
      .ACC_W    (ACC_W)
    ) u_br (
      .clk      (clk),
      .rst      (rst),
      .shift_en (br_en[p]),
      .din      (in_sample),
      .capture  (cap_r),
      .partial  (parts[p])
    );
  end

  pd_combine #(.NPHASE(NPHASE), .ACC_W(ACC_W)) u_comb (
    .clk       (clk),
    .rst       (rst),
    .go        (part_rdy),
    .parts     (parts),
    .dout      (dout),
    .out_valid (out_valid)
  );

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R6
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(grp_done, 3));
  // R7
  grp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    grp_done |=> !grp_done);

endmodule

// File: tb/pd_decim3_bench.sv
`timescale 1ns/1ps
module pd_decim3_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_sample = '0;
  logic [31:0] dout;
  logic        out_valid;

  pd_decim3 u_pd_decim3 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .dout(dout), .out_valid(out_valid)
  );

  always #10 clk = ~clk;

  int  n_checks = 0;
  int  n_fails  = 0;
  int  cyc      = 0;
  bit  done     = 0;
  string tag    = "R5";

  int  xs [0:1023];
  int  nx = 0;
  longint exp_y [0:511];
  int  due   [0:511];
  int  wr = 0;
  int  rd = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  // Coefficient rule restated with repeated subtraction.
  function automatic int hb(input int k);
    int t;
    t = 5 + 23 * k;
    while (t >= 62) t = t - 62;
    return t + 1;
  endfunction

  task automatic check(input string r, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (act != expv) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, expv);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Drives one sample at a falling edge; schedules the expected output.
  task automatic put(input int v);
    longint y;
    int m;
    in_valid  = 1'b1;
    in_sample = v[7:0];
    @(negedge clk);
    in_valid = 1'b0;
    step_lfsr();
    in_sample = lfsr[7:0];
    xs[nx] = v;
    nx++;
    if (nx % 3 == 0) begin
      m = nx / 3 - 1;
      y = 0;
      for (int k = 0; k < 18; k++)
        if (3 * m + 2 - k >= 0) y += longint'(hb(k)) * xs[3 * m + 2 - k];
      exp_y[wr] = y;
      due[wr]   = cyc + 2;
      wr++;
    end
  endtask

  // Idle cycles with garbage on the data pins (R2).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step_lfsr();
      in_sample = lfsr[15:8];
      @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (rd < wr && due[rd] == cyc) begin
          check(tag, "decimated output (R5 R6)", dout, exp_y[rd]);
          rd++;
        end else begin
          check("R6", "unscheduled out_valid (R7)", 1, 0);
        end
      end else if (rd < wr && due[rd] == cyc) begin
        check("R6", "missing out_valid", 0, 1);
        rd++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "dout after reset", dout, 0);
    check("R1", "out_valid after reset", out_valid, 0);

    // R3: impulse at each group offset exposes every coefficient
    tag = "R3";
    put(1);
    for (int i = 0; i < 20; i++) put(0);
    idle(4);
    put(0); put(200);
    for (int i = 0; i < 19; i++) begin put(0); idle(i % 3); end
    idle(4);
    put(0); put(0); put(77);
    for (int i = 0; i < 18; i++) put(0);
    idle(5);

    // R4: full-scale input, back-to-back (R8)
    tag = "R4";
    for (int i = 0; i < 30; i++) put(255);
    idle(5);

    // R7: ramp with varying gaps
    tag = "R7";
    for (int i = 0; i < 40; i++) begin put(i * 6 + 1); idle((i * 5) % 4); end
    idle(5);

    // R8: long back-to-back run
    tag = "R8";
    for (int i = 0; i < 60; i++) begin step_lfsr(); put(lfsr[7:0]); end
    idle(5);

    // R5: pseudo-random samples and gaps
    tag = "R5";
    for (int i = 0; i < 300; i++) begin
      step_lfsr();
      put(lfsr[7:0]);
      idle(lfsr[9:8] == 2'b11 ? 2 : 0);
    end
    idle(5);

    // R1: reset in the middle of a group clears history and rotation
    tag = "R1";
    put(90); put(91); put(92); put(93);
    idle(5);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    nx = 0;
    check("R1", "dout after mid reset", dout, 0);
    check("R1", "out_valid after mid reset", out_valid, 0);
    for (int i = 0; i < 12; i++) put(10 + i * 20);
    idle(6);

    check("R7", "outputs produced vs scheduled", rd, wr);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule